// File: doc/BRIEF.md
# Double-Buffered Sound Register Write Queue

This block sits beside a sound chip's register interface and records which register writes a remote sound engine has to replay. Each accepted write arrives as a 2-bit port number and an 8-bit value. The block drops writes that would change nothing on the remote side and packs each remaining write into a 16-bit word. It stores that word in one half of a two-bank queue memory. The remote engine reads the other half.

When a write that changes the sound output lands late in the visible part of the frame, the block first puts a one-shot timing marker into the queue. The marker lets the consumer place the following writes in time. The frame-end strobe closes the filling half with a terminator word, resets the fill index and swaps the halves.

The memory write port has two lanes. Lane 0 writes at `mem_addr`. Lane 1 is used only together with lane 0 and writes at `mem_addr + 1`. This lets the marker and the write that caused it be stored in the same cycle. Every output is registered and changes one clock after the input cycle that causes it.

Top module: `regwr_dbl_queue`

## Requirements
- R1: A kept write is stored as {6'b0, port[1:0], data[7:0]} on lane 0. The address is {~buf_sel, fill index}, so the write goes to the half the consumer does not own, at the current fill index. The fill index then advances by one. Port codes: 0 = bank-0 address, 1 = bank-0 data, 2 = bank-1 address, 3 = bank-1 data.
- R2: An address write on port 0 or 2 is dropped when the latched address already equals the value and the latched bank matches the port (port 0 = bank 0, port 2 = bank 1). After reset the latch holds address 0x00 on bank 0.
- R3: A port-0 address write of 0x24, 0x25, 0x26 or 0x2A is dropped when bank 0 is already latched, but the address is still latched. A port-1 data write is dropped while the latched address is one of these four.
- R4: A data write whose bank (port 1 = bank 0, port 3 = bank 1) differs from the latched bank is dropped.
- R5: A port-1 data write to bank-0 address 0x27 is kept only when its bits 7:6 differ from bits 7:6 of the last such write. After reset those bits are 00.
- R6: One half holds at most 2047 entries (indices 0 to 2046). A write that finds no free index is dropped and sets the sticky `overflow` output.
- R7: The marker 0xFFFE is stored before a kept write when four conditions all hold: the write has `wr_snd` set, the scanline is below 224, the scanline is above the midpoint (68 when `pal_sel` = 1, 93 when it is 0), and no marker has been inserted in this frame. The marker goes on lane 0 and the write on lane 1 at the next index. If only one index is free, the marker is stored and the write is dropped.
- R8: On `frame_end`, lane 0 writes 0xFFFF at the current fill index of the filling half. The fill index returns to 0, `buf_sel` toggles, `overflow` clears and the marker is re-armed. A write presented in the same cycle is discarded and does not change the filter state.
- R9: After reset `buf_sel` = 0, `overflow` = 0 and no lane writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A register write is presented this cycle |
| wr_port | input | 2 | Port code of the write |
| wr_data | input | 8 | Value written |
| wr_snd | input | 1 | The write changes sound output |
| scanline | input | 9 | Current display line |
| pal_sel | input | 1 | 1 selects the 50 Hz midpoint, 0 the 60 Hz one |
| frame_end | input | 1 | One-cycle frame-close strobe |
| mem_we | output | 2 | Lane write enables (bit 1 only with bit 0) |
| mem_addr | output | 12 | Lane-0 address: half select in bit 11, index below |
| mem_wdata0 | output | 16 | Lane-0 word |
| mem_wdata1 | output | 16 | Lane-1 word, stored at mem_addr + 1 |
| buf_sel | output | 1 | Half owned by the consumer |
| overflow | output | 1 | An entry was dropped for lack of room this frame |

## Verification
The hardest case to reach is a late sound-affecting write that arrives when exactly one index is left in the filling half. In that case the marker takes the last slot, the write is lost and `overflow` must rise. The stimulus reaches this case directly. It latches a plain bank-0 register and then sends 2046 non-sound data writes to fill indices 0 to 2045. It follows with one late sound write and one more write. A frame close after that shows the terminator landing at index 2047. Random traffic mixes in the filtered addresses and the frame strobe, so the redundancy and mode-bit rules are also hit across frame boundaries.

// File: rtl/regwr_q_pkg.sv
package regwr_q_pkg;

  typedef enum logic [1:0] {
    PORT_ADDR0 = 2'd0,
    PORT_DATA0 = 2'd1,
    PORT_ADDR1 = 2'd2,
    PORT_DATA1 = 2'd3
  } port_e;

  localparam logic [15:0] WORD_LATE = 16'hFFFE;
  localparam logic [15:0] WORD_END  = 16'hFFFF;
  localparam logic [7:0]  REG_MODE  = 8'h27;

  // registers serviced locally, never replayed remotely
  function automatic logic is_local_reg(input logic [7:0] a);
    return (a == 8'h24) || (a == 8'h25) || (a == 8'h26) || (a == 8'h2A);
  endfunction

  function automatic logic [15:0] pack_entry(input logic [1:0] p, input logic [7:0] d);
    return {6'b0, p, d};
  endfunction

endpackage

// File: rtl/regwr_filter.sv
module regwr_filter
  import regwr_q_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] in_port,
  input  logic [7:0] in_data,
  output logic       keep
);

  logic [7:0] addr_q, addr_d;
  logic       bank_q, bank_d;
  logic [1:0] mode_q, mode_d;

  always_comb begin
    keep   = 1'b0;
    addr_d = addr_q;
    bank_d = bank_q;
    mode_d = mode_q;
    if (in_valid) begin
      case (port_e'(in_port))
        PORT_ADDR0: begin
          if (!(!bank_q && addr_q == in_data)) begin
            addr_d = in_data;
            bank_d = 1'b0;
            keep   = !(!bank_q && is_local_reg(in_data));
          end
        end
        PORT_DATA0: begin
          if (!bank_q) begin
            if (addr_q == REG_MODE) begin
              mode_d = in_data[7:6];
              keep   = (in_data[7:6] != mode_q);
            end else begin
              keep = !is_local_reg(addr_q);
            end
          end
        end
        PORT_ADDR1: begin
          if (!(bank_q && addr_q == in_data)) begin
            addr_d = in_data;
            bank_d = 1'b1;
            keep   = 1'b1;
          end
        end
        default: keep = bank_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bank_q <= 1'b0;
      mode_q <= '0;
    end else if (in_valid) begin
      addr_q <= addr_d;
      bank_q <= bank_d;
      mode_q <= mode_d;
    end
  end

  AST_ADDR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_port[0]) |=> (addr_q == $past(in_data))) else $error("addr latch"); // R2

  AST_BANK1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_port == 2'd2) |=> bank_q) else $error("bank latch"); // R4

  AST_MODE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_port == 2'd1 && !bank_q && addr_q == REG_MODE)
      |=> (mode_q == $past(in_data[7:6]))) else $error("mode track"); // R5

endmodule

// File: rtl/regwr_late_mark.sv
module regwr_late_mark #(
  parameter int LINE_W       = 9,
  parameter int ACTIVE_LINES = 224,
  parameter int MID_PAL      = 68,
  parameter int MID_NTSC     = 93
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keep,
  input  logic              snd,
  input  logic [LINE_W-1:0] scanline,
  input  logic              pal_sel,
  input  logic              frame_end,
  output logic              ins_marker
);

  localparam logic [LINE_W-1:0] LIM_ACT  = LINE_W'(ACTIVE_LINES);
  localparam logic [LINE_W-1:0] LIM_PAL  = LINE_W'(MID_PAL);
  localparam logic [LINE_W-1:0] LIM_NTSC = LINE_W'(MID_NTSC);

  logic              done_q, done_d;
  logic [LINE_W-1:0] mid;
  logic              in_window;

  always_comb begin
    mid        = pal_sel ? LIM_PAL : LIM_NTSC;
    in_window  = (scanline < LIM_ACT) && (scanline > mid);
    ins_marker = keep && snd && in_window && !done_q;
    if (frame_end) done_d = 1'b0;
    else           done_d = done_q | ins_marker;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  AST_MARK_ARMS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ins_marker |=> done_q) else $error("marker not latched"); // R7

  AST_MARK_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !done_q) else $error("marker not rearmed"); // R8

endmodule

// File: rtl/regwr_fill_ctrl.sv
module regwr_fill_ctrl
  import regwr_q_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           keep,
  input  logic           ins_marker,
  input  logic           frame_end,
  input  logic [15:0]    entry,
  output logic [1:0]     mem_we,
  output logic [PTR_W:0] mem_addr,
  output logic [15:0]    mem_wdata0,
  output logic [15:0]    mem_wdata1,
  output logic           buf_sel,
  output logic           overflow
);

  localparam logic [PTR_W-1:0] CAP    = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] CAP_M1 = PTR_W'(DEPTH - 2);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             sel_q, sel_d;
  logic             ovf_q, ovf_d;
  logic [1:0]       we_q, we_d;
  logic [PTR_W:0]   addr_q, addr_d;
  logic [15:0]      d0_q, d0_d, d1_q, d1_d;

  always_comb begin
    we_d   = 2'b00;
    addr_d = {~sel_q, ptr_q};
    d0_d   = entry;
    d1_d   = entry;
    ptr_d  = ptr_q;
    sel_d  = sel_q;
    ovf_d  = ovf_q;
    if (frame_end) begin
      we_d  = 2'b01;
      d0_d  = WORD_END;
      ptr_d = '0;
      sel_d = ~sel_q;
      ovf_d = 1'b0;
    end else if (keep) begin
      if (ins_marker) begin
        if (ptr_q < CAP) begin
          we_d[0] = 1'b1;
          d0_d    = WORD_LATE;
          if (ptr_q < CAP_M1) begin
            we_d[1] = 1'b1;
            ptr_d   = ptr_q + PTR_W'(2);
          end else begin
            ptr_d = ptr_q + PTR_W'(1);
            ovf_d = 1'b1;
          end
        end else begin
          ovf_d = 1'b1;
        end
      end else if (ptr_q < CAP) begin
        we_d  = 2'b01;
        ptr_d = ptr_q + PTR_W'(1);
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      sel_q <= 1'b0;
      ovf_q <= 1'b0;
      we_q  <= 2'b00;
    end else begin
      ptr_q <= ptr_d;
      sel_q <= sel_d;
      ovf_q <= ovf_d;
      we_q  <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
    end else begin
      if (we_d[0]) begin
        addr_q <= addr_d;
        d0_q   <= d0_d;
      end
      if (we_d[1]) d1_q <= d1_d;
    end
  end

  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata0 = d0_q;
  assign mem_wdata1 = d1_q;
  assign buf_sel    = sel_q;
  assign overflow   = ovf_q;

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= CAP) else $error("index past capacity"); // R6

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (keep && !frame_end && ptr_q == CAP) |=> (overflow && mem_we == 2'b00)) else $error("full drop"); // R6

  AST_LANE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we[1] |-> (mem_we[0] && mem_wdata0 == WORD_LATE)) else $error("lane pairing"); // R7

  AST_FE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (buf_sel != $past(buf_sel) && !overflow && ptr_q == '0
                   && mem_we == 2'b01 && mem_wdata0 == WORD_END)) else $error("frame close"); // R8

  AST_WRITE_OTHER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we[0] && mem_wdata0 != WORD_END) |-> (mem_addr[PTR_W] != buf_sel)) else $error("wrong half"); // R1

endmodule

// File: rtl/regwr_dbl_queue.sv
module regwr_dbl_queue
  import regwr_q_pkg::*;
#(
  parameter int DEPTH        = 2048,
  parameter int LINE_W       = 9,
  parameter int ACTIVE_LINES = 224,
  parameter int MID_PAL      = 68,
  parameter int MID_NTSC     = 93,
  localparam int PTR_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [1:0]        wr_port,
  input  logic [7:0]        wr_data,
  input  logic              wr_snd,
  input  logic [LINE_W-1:0] scanline,
  input  logic              pal_sel,
  input  logic              frame_end,
  output logic [1:0]        mem_we,
  output logic [PTR_W:0]    mem_addr,
  output logic [15:0]       mem_wdata0,
  output logic [15:0]       mem_wdata1,
  output logic              buf_sel,
  output logic              overflow
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       take;
  logic       keep;
  logic       ins_marker;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign take = wr_valid && !frame_end;

  regwr_filter u_filter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (take),
    .in_port  (wr_port),
    .in_data  (wr_data),
    .keep     (keep)
  );

  regwr_late_mark #(
    .LINE_W       (LINE_W),
    .ACTIVE_LINES (ACTIVE_LINES),
    .MID_PAL      (MID_PAL),
    .MID_NTSC     (MID_NTSC)
  ) u_late (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .keep       (keep),
    .snd        (wr_snd),
    .scanline   (scanline),
    .pal_sel    (pal_sel),
    .frame_end  (frame_end),
    .ins_marker (ins_marker)
  );

  regwr_fill_ctrl #(
    .DEPTH (DEPTH)
  ) u_fill (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .keep       (keep),
    .ins_marker (ins_marker),
    .frame_end  (frame_end),
    .entry      (pack_entry(wr_port, wr_data)),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata0 (mem_wdata0),
    .mem_wdata1 (mem_wdata1),
    .buf_sel    (buf_sel),
    .overflow   (overflow)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (mem_we == 2'b00 && !buf_sel && !overflow)) else $error("reset state"); // R9

endmodule

// File: tb/regwr_dbl_queue_tb.sv
module regwr_dbl_queue_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_snd, pal_sel, frame_end;
  logic [1:0]  wr_port;
  logic [7:0]  wr_data;
  logic [8:0]  scanline;
  logic [1:0]  mem_we;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata0, mem_wdata1;
  logic        buf_sel, overflow;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  regwr_dbl_queue u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_port(wr_port),
    .wr_data(wr_data), .wr_snd(wr_snd), .scanline(scanline), .pal_sel(pal_sel),
    .frame_end(frame_end), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata0(mem_wdata0), .mem_wdata1(mem_wdata1), .buf_sel(buf_sel),
    .overflow(overflow)
  );

  // reference state, from the requirements
  int m_addr, m_bank, m_mode, m_ptr, m_sel, m_ovf, m_done;

  function automatic bit is_loc(int a);
    return (a == 'h24) || (a == 'h25) || (a == 'h26) || (a == 'h2A);
  endfunction

  // returns keep; updates latch state; sets why tag
  function automatic bit ref_filter(int p, int d, output string why);
    bit k = 0;
    why = "R1";
    case (p)
      0: if (m_bank == 0 && m_addr == d) why = "R2";
         else begin
           k = !(m_bank == 0 && is_loc(d));
           if (!k) why = "R3";
           m_addr = d; m_bank = 0;
         end
      1: if (m_bank != 0) why = "R4";
         else if (m_addr == 'h27) begin
           k = ((d >> 6) != m_mode); why = "R5"; m_mode = d >> 6;
         end else begin
           k = !is_loc(m_addr); if (!k) why = "R3";
         end
      2: if (m_bank == 1 && m_addr == d) why = "R2";
         else begin k = 1; m_addr = d; m_bank = 1; end
      default: begin k = (m_bank == 1); if (!k) why = "R4"; end
    endcase
    return k;
  endfunction

  task automatic step(input bit v, input int p, input int d, input bit s,
                      input int ln, input bit pal, input bit fe);
    int e_we = 0, e_a = 0, e_d0 = 0, e_d1 = 0;
    string why;
    bit ok;
    wr_valid = v; wr_port = p[1:0]; wr_data = d[7:0]; wr_snd = s;
    scanline = ln[8:0]; pal_sel = pal; frame_end = fe;
    why = "R1";
    if (fe) begin
      e_we = 1; e_a = ((1 - m_sel) << 11) | m_ptr; e_d0 = 'hFFFF;
      m_ptr = 0; m_sel = 1 - m_sel; m_ovf = 0; m_done = 0; why = "R8";
    end else if (v) begin
      if (ref_filter(p, d, why)) begin
        int mid = pal ? 68 : 93;
        int ent = ((p & 3) << 8) | (d & 'hFF);
        e_a = ((1 - m_sel) << 11) | m_ptr;
        if (s && ln < 224 && ln > mid && !m_done) begin
          m_done = 1; why = "R7";
          if (m_ptr < 2047) begin
            e_we = 1; e_d0 = 'hFFFE;
            if (m_ptr < 2046) begin e_we = 3; e_d1 = ent; m_ptr += 2; end
            else begin m_ptr += 1; m_ovf = 1; why = "R6"; end
          end else begin m_ovf = 1; why = "R6"; end
        end else if (m_ptr < 2047) begin
          e_we = 1; e_d0 = ent; m_ptr += 1;
        end else begin m_ovf = 1; why = "R6"; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    ok = (int'(mem_we) == e_we) && (int'(buf_sel) == m_sel) && (int'(overflow) == m_ovf);
    if (e_we[0] && (int'(mem_addr) != e_a || int'(mem_wdata0) != e_d0)) ok = 0;
    if (e_we[1] && int'(mem_wdata1) != e_d1) ok = 0;
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got we=%0d addr=%h d0=%h d1=%h sel=%0d ovf=%0d, expected we=%0d addr=%h d0=%h d1=%h sel=%0d ovf=%0d",
               why, mem_we, mem_addr, mem_wdata0, mem_wdata1, buf_sel, overflow,
               e_we, e_a, e_d0, e_d1, m_sel, m_ovf);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got no end, expected end of run");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    m_addr = 0; m_bank = 0; m_mode = 0; m_ptr = 0; m_sel = 0; m_ovf = 0; m_done = 0;
    rst_n = 1'b0; wr_valid = 0; wr_port = 0; wr_data = 0; wr_snd = 0;
    scanline = 0; pal_sel = 0; frame_end = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    n_chk++;
    if (mem_we != 2'b00 || buf_sel != 1'b0 || overflow != 1'b0) begin
      n_bad++;
      $display("FAIL R9: got we=%0d sel=%0d ovf=%0d, expected 0 0 0", mem_we, buf_sel, overflow);
    end
    // R2 reset latch is 0x00 bank 0
    step(1, 0, 'h00, 0, 0, 0, 0);
    step(1, 0, 'h30, 0, 0, 0, 0);   // R1 kept
    step(1, 0, 'h30, 0, 0, 0, 0);   // R2 dropped
    step(1, 1, 'h55, 0, 0, 0, 0);   // R1 data kept
    // R3 local registers
    step(1, 0, 'h24, 0, 0, 0, 0);
    step(1, 1, 'h11, 0, 0, 0, 0);
    step(1, 2, 'h24, 0, 0, 0, 0);   // bank 1 kept
    step(1, 0, 'h24, 0, 0, 0, 0);   // from bank 1: kept
    step(1, 2, 'h24, 0, 0, 0, 0);   // bank switch back kept
    // R4 bank mismatch
    step(1, 1, 'h66, 0, 0, 0, 0);
    step(1, 3, 'h77, 0, 0, 0, 0);   // bank 1 data kept
    step(1, 0, 'h40, 0, 0, 0, 0);
    step(1, 3, 'h78, 0, 0, 0, 0);
    // R5 mode bits
    step(1, 0, 'h27, 0, 0, 0, 0);
    step(1, 1, 'h15, 0, 0, 0, 0);
    step(1, 1, 'h40, 0, 0, 0, 0);
    step(1, 1, 'h7F, 0, 0, 0, 0);
    step(1, 1, 'hC0, 0, 0, 0, 0);
    // R7 marker window and once-per-frame
    step(1, 0, 'h30, 0, 0, 0, 0);
    step(1, 1, 'h01, 1, 68, 1, 0);  // pal boundary: no marker
    step(1, 1, 'h02, 1, 69, 1, 0);  // marker
    step(1, 1, 'h03, 1, 100, 1, 0); // already inserted
    step(1, 1, 'h04, 0, 0, 0, 1);   // R8 close, write discarded
    step(1, 1, 'h05, 1, 224, 0, 0); // R7 bottom limit
    step(1, 1, 'h06, 1, 93, 0, 0);  // ntsc boundary
    step(1, 1, 'h07, 0, 150, 0, 0); // not sound-affecting
    step(1, 1, 'h08, 1, 94, 0, 0);  // marker
    step(0, 0, 0, 0, 0, 0, 1);      // R8
    // R6 fill to the last slot, then a late sound write
    for (int i = 0; i < 2046; i++) step(1, 1, i & 'hFF, 0, 0, 0, 0);
    step(1, 1, 'hAA, 1, 120, 0, 0); // marker takes last slot, write lost
    step(1, 1, 'hBB, 0, 0, 0, 0);   // R6 full
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);      // R8 terminator at 2047, ovf clears
    // R6 full without marker
    for (int i = 0; i < 2048; i++) step(1, 1, 'h10, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int pick = $urandom_range(0, 9);
      int dv = (pick < 7) ? int'(pick == 0 ? 'h24 : pick == 1 ? 'h25 : pick == 2 ? 'h26 :
                                 pick == 3 ? 'h2A : pick == 4 ? 'h27 : pick == 5 ? 'h30 : 'h31)
                          : int'($urandom_range(0, 255));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3), dv,
           $urandom_range(0, 1), $urandom_range(0, 262), $urandom_range(0, 1),
           $urandom_range(0, 39) == 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule